// File: doc/BRIEF.md
# Per-Port Source Address Monitor

This block watches the source address of every packet that finishes on any port of a multi-port repeater. It keeps two addresses for each port. One is a learned address, which is the last one seen. The other is a preferred address that management programs. When a packet ends, the block compares its source address against both. A disagreement with either one flags an address change for that port. A disagreement with the preferred address also flags a possible intruder on that port.

Both flags are sticky status bits. Each kind has its own per-port enable mask, and a single interrupt line reports any enabled, pending flag. The learned address follows the traffic by itself, with two exceptions: management can freeze it per port with a lock bit, and only packets marked valid are learned.

The default build has fifteen ports. Ports 0 to 11 are the twelve repeater ports, port 12 is the attachment-unit port, port 13 is the remote attachment-unit port, and port 14 is the expansion port. The expansion port can raise an address change but never an intruder flag.

A simple configuration port handles all management access. On a write strobe, `cfg_sel` selects a register and `cfg_wdata` carries the value. Reads are combinational from `cfg_sel` and `cfg_port`. The selector codes are:

| Code | Register | Access |
|------|----------|--------|
| 0 | Preferred address of `cfg_port` | read and write |
| 1 | Learned address of `cfg_port` | read only |
| 2 | Lock mask | read and write |
| 3 | Change-enable mask | read and write |
| 4 | Intruder-enable mask | read and write |
| 5 | Change status | read, write 1 to clear |
| 6 | Intruder status | read, write 1 to clear |
| 7 | None | reads as zero |

Mask and status registers use bit n for port n.

Top module: `sam_monitor`

## Requirements
- R1: On a cycle with `pkt_eop` high and an in-range `pkt_port`, the change status bit of that port sets at that clock edge if `pkt_sa` differs from the port's learned address or from its preferred address. If `pkt_sa` equals both, the change status bit is not set.
- R2: At the same event, a mismatch with the preferred address sets the intruder status bit, but only for ports below `INTR_PORTS`. Intruder status bits and intruder-enable bits at or above `INTR_PORTS` always read 0.
- R3: When the packet is valid (`pkt_valid`=1), the port is unlocked, and `pkt_sa` differs from the learned address, the learned address takes `pkt_sa` at that edge. The new value is readable with selector 1.
- R4: A port whose lock bit is set, or a packet with `pkt_valid`=0, leaves the learned address unchanged. Status bits are still updated as in R1 and R2.
- R5: Status bits stay set until management writes 1 to them (selector 5 or 6). When a set and a clear reach the same bit in the same cycle, the set wins.
- R6: `irq` is high exactly when some change status bit has its change-enable bit at 1, or some intruder status bit has its intruder-enable bit at 1. An enable bit of 0 masks its status bit.
- R7: `intr_status` shows the intruder status bits directly.
- R8: A packet event whose `pkt_port` is `NUM_PORTS` or greater changes no status bit and no stored address.
- R9: After reset, all stored addresses, locks, enables and status bits are 0, and `irq` is low.
- R10: Writes with selectors 0, 2, 3 and 4 are read back through `cfg_rdata` using the same code. Selector 0 affects only the port given by `cfg_port`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pkt_eop | input | 1 | End-of-packet strobe, one cycle per packet |
| pkt_port | input | PW | Port on which the packet ended |
| pkt_sa | input | ADDR_W | Source address of the packet |
| pkt_valid | input | 1 | Packet was received without error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register selector, coded as listed above |
| cfg_port | input | PW | Port index for selectors 0 and 1 |
| cfg_wdata | input | ADDR_W | Write data; masks use the low NUM_PORTS bits |
| cfg_rdata | output | ADDR_W | Combinational read data |
| irq | output | 1 | Interrupt, high while any enabled status bit is pending |
| intr_status | output | NUM_PORTS | Sticky intruder status, one bit per port |

## Verification
The bench builds the block with five ports, four of which can raise intruder flags, and with 16-bit addresses. Port 4 therefore plays the role of the expansion port, so the intruder gating described in R2 is exercised. Port indices 5 to 7 fit in the three-bit index but are out of range, which is how R8 is exercised. A small random address pool makes matches and mismatches against both stored addresses frequent. A random phase then mixes lock changes, clears that land in the same cycle as sets, and invalid packets.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [2:0] {
    SEL_PREF    = 3'd0,
    SEL_LAST    = 3'd1,
    SEL_LOCK    = 3'd2,
    SEL_CHG_EN  = 3'd3,
    SEL_INTR_EN = 3'd4,
    SEL_CHG_ST  = 3'd5,
    SEL_INTR_ST = 3'd6,
    SEL_NONE    = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/sam_addr_bank.sv
module sam_addr_bank #(
  parameter int NUM_PORTS = 15,
  parameter int ADDR_W    = 48,
  parameter int PW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pref_we,
  input  logic [PW-1:0]     pref_idx,
  input  logic [ADDR_W-1:0] pref_d,
  input  logic              learn_we,
  input  logic [PW-1:0]     learn_idx,
  input  logic [ADDR_W-1:0] learn_d,
  input  logic [PW-1:0]     cmp_idx,
  input  logic [ADDR_W-1:0] cmp_sa,
  output logic              miss_last,
  output logic              miss_pref,
  input  logic [PW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_pref,
  output logic [ADDR_W-1:0] rd_last
);
  logic [ADDR_W-1:0] pref_q [NUM_PORTS];
  logic [ADDR_W-1:0] last_q [NUM_PORTS];
  logic [ADDR_W-1:0] cmp_last, cmp_pref;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic pref_en, last_en;
    assign pref_en = pref_we  && (pref_idx  == PW'(g));
    assign last_en = learn_we && (learn_idx == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pref_q[g] <= '0;
      else if (pref_en) pref_q[g] <= pref_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q[g] <= '0;
      else if (last_en) last_q[g] <= learn_d;
    end
  end

  always_comb begin
    cmp_last = '0;
    cmp_pref = '0;
    rd_last  = '0;
    rd_pref  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (cmp_idx == PW'(i)) begin
        cmp_last = last_q[i];
        cmp_pref = pref_q[i];
      end
      if (rd_idx == PW'(i)) begin
        rd_last = last_q[i];
        rd_pref = pref_q[i];
      end
    end
  end

  assign miss_last = (cmp_sa != cmp_last);
  assign miss_pref = (cmp_sa != cmp_pref);
endmodule

// File: rtl/sam_mask_reg.sv
module sam_mask_reg #(
  parameter int           W     = 15,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we) nxt = d & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sam_sticky.sv
module sam_sticky #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // a set in the same cycle overrides a clear
  always_comb nxt = (q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sam_monitor.sv
module sam_monitor #(
  parameter int NUM_PORTS  = 15,
  parameter int INTR_PORTS = 14,
  parameter int ADDR_W     = 48,
  parameter int PW         = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_eop,
  input  logic [PW-1:0]        pkt_port,
  input  logic [ADDR_W-1:0]    pkt_sa,
  input  logic                 pkt_valid,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [PW-1:0]        cfg_port,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [ADDR_W-1:0]    cfg_rdata,
  output logic                 irq,
  output logic [NUM_PORTS-1:0] intr_status
);
  import sam_pkg::*;

  localparam logic [NUM_PORTS-1:0] INTR_CAP = {NUM_PORTS{1'b1}} >> (NUM_PORTS - INTR_PORTS);
  localparam logic [NUM_PORTS-1:0] ALL_ONES = {NUM_PORTS{1'b1}};

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  logic                 pkt_in_range, cfg_in_range, pkt_ev;
  logic [NUM_PORTS-1:0] pkt_hot;
  assign pkt_in_range = ({1'b0, pkt_port} < (PW+1)'(NUM_PORTS));
  assign cfg_in_range = ({1'b0, cfg_port} < (PW+1)'(NUM_PORTS));
  assign pkt_ev       = pkt_eop && pkt_in_range;
  assign pkt_hot      = pkt_ev ? (NUM_PORTS'(1) << pkt_port) : '0;

  logic [NUM_PORTS-1:0] lock_q, chg_en_q, intr_en_q, chg_q, intr_q;
  logic                 miss_last, miss_pref, port_locked, learn_we, pref_we;
  logic [ADDR_W-1:0]    rd_pref, rd_last;

  assign port_locked = |(pkt_hot & lock_q);
  assign learn_we    = pkt_ev && pkt_valid && miss_last && !port_locked;
  assign pref_we     = cfg_we && (sel == SEL_PREF) && cfg_in_range;

  sam_addr_bank #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_q_n),
    .pref_we(pref_we), .pref_idx(cfg_port), .pref_d(cfg_wdata),
    .learn_we(learn_we), .learn_idx(pkt_port), .learn_d(pkt_sa),
    .cmp_idx(pkt_port), .cmp_sa(pkt_sa),
    .miss_last(miss_last), .miss_pref(miss_pref),
    .rd_idx(cfg_port), .rd_pref(rd_pref), .rd_last(rd_last)
  );

  logic mwe_lock, mwe_chg, mwe_intr;
  assign mwe_lock = cfg_we && (sel == SEL_LOCK);
  assign mwe_chg  = cfg_we && (sel == SEL_CHG_EN);
  assign mwe_intr = cfg_we && (sel == SEL_INTR_EN);

  sam_mask_reg #(.W(NUM_PORTS), .WMASK(ALL_ONES)) u_lock (
    .clk(clk), .rst_n(rst_q_n), .we(mwe_lock), .d(cfg_wdata[NUM_PORTS-1:0]), .q(lock_q));
  sam_mask_reg #(.W(NUM_PORTS), .WMASK(ALL_ONES)) u_chg_en (
    .clk(clk), .rst_n(rst_q_n), .we(mwe_chg), .d(cfg_wdata[NUM_PORTS-1:0]), .q(chg_en_q));
  sam_mask_reg #(.W(NUM_PORTS), .WMASK(INTR_CAP)) u_intr_en (
    .clk(clk), .rst_n(rst_q_n), .we(mwe_intr), .d(cfg_wdata[NUM_PORTS-1:0]), .q(intr_en_q));

  logic [NUM_PORTS-1:0] chg_set, intr_set, chg_clr, intr_clr;
  assign chg_set  = (miss_last || miss_pref) ? pkt_hot : '0;
  assign intr_set = miss_pref ? (pkt_hot & INTR_CAP) : '0;
  assign chg_clr  = (cfg_we && (sel == SEL_CHG_ST))  ? cfg_wdata[NUM_PORTS-1:0] : '0;
  assign intr_clr = (cfg_we && (sel == SEL_INTR_ST)) ? cfg_wdata[NUM_PORTS-1:0] : '0;

  sam_sticky #(.W(NUM_PORTS)) u_chg_st (
    .clk(clk), .rst_n(rst_q_n), .set(chg_set), .clr(chg_clr), .q(chg_q));
  sam_sticky #(.W(NUM_PORTS)) u_intr_st (
    .clk(clk), .rst_n(rst_q_n), .set(intr_set), .clr(intr_clr), .q(intr_q));

  assign irq         = (|(chg_q & chg_en_q)) | (|(intr_q & intr_en_q));
  assign intr_status = intr_q;

  always_comb begin
    unique case (sel)
      SEL_PREF:    cfg_rdata = cfg_in_range ? rd_pref : '0;
      SEL_LAST:    cfg_rdata = cfg_in_range ? rd_last : '0;
      SEL_LOCK:    cfg_rdata = ADDR_W'(lock_q);
      SEL_CHG_EN:  cfg_rdata = ADDR_W'(chg_en_q);
      SEL_INTR_EN: cfg_rdata = ADDR_W'(intr_en_q);
      SEL_CHG_ST:  cfg_rdata = ADDR_W'(chg_q);
      SEL_INTR_ST: cfg_rdata = ADDR_W'(intr_q);
      default:     cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sam_monitor_chk.sv
module sam_monitor_chk #(
  parameter int NUM_PORTS  = 15,
  parameter int INTR_PORTS = 14,
  parameter int PW         = 4
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 pkt_eop,
  input logic [PW-1:0]        pkt_port,
  input logic                 pkt_valid,
  input logic                 learn_we,
  input logic [NUM_PORTS-1:0] chg_q,
  input logic [NUM_PORTS-1:0] intr_q,
  input logic                 irq
);
  assert_intr_has_chg_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (intr_q & ~$past(intr_q) & ~chg_q) == '0);

  if (INTR_PORTS < NUM_PORTS) begin : g_upper
    assert_upper_no_intr_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
      intr_q[NUM_PORTS-1:INTR_PORTS] == '0);
  end

  assert_set_needs_eop_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(pkt_eop) |-> ((chg_q & ~$past(chg_q)) == '0));

  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(pkt_eop && ({1'b0, pkt_port} >= (PW+1)'(NUM_PORTS)))
      |-> (((chg_q & ~$past(chg_q)) == '0) && ((intr_q & ~$past(intr_q)) == '0)));

  assert_learn_valid_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    learn_we |-> (pkt_eop && pkt_valid));

  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> ((chg_q != '0) || (intr_q != '0)));
endmodule

bind sam_monitor sam_monitor_chk #(.NUM_PORTS(NUM_PORTS), .INTR_PORTS(INTR_PORTS), .PW(PW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .pkt_eop(pkt_eop), .pkt_port(pkt_port),
  .pkt_valid(pkt_valid), .learn_we(learn_we), .chg_q(chg_q), .intr_q(intr_q), .irq(irq));

// File: tb/tb_sam_monitor.sv
module tb_sam_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int IP = 4;
  localparam int AW = 16;
  localparam int PW = 3;

  logic          clk, rst_n;
  logic          pkt_eop, pkt_valid, cfg_we;
  logic [PW-1:0] pkt_port, cfg_port;
  logic [AW-1:0] pkt_sa, cfg_wdata, cfg_rdata;
  logic [2:0]    cfg_sel;
  logic          irq;
  logic [NP-1:0] intr_status;

  int n_cmp = 0;
  int n_bad = 0;

  sam_monitor #(.NUM_PORTS(NP), .INTR_PORTS(IP), .ADDR_W(AW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_eop(pkt_eop), .pkt_port(pkt_port), .pkt_sa(pkt_sa),
    .pkt_valid(pkt_valid), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_port(cfg_port),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .intr_status(intr_status));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_pref [NP];
  int m_last [NP];
  bit m_lock [NP], m_chgen [NP], m_intren [NP], m_chg [NP], m_intr [NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_pref[i] = 0; m_last[i] = 0; m_lock[i] = 0; m_chgen[i] = 0;
        m_intren[i] = 0; m_chg[i] = 0; m_intr[i] = 0;
      end
    end else begin
      bit set_c [NP];
      bit set_i [NP];
      int p, sa, wd;
      bit do_learn;
      p = int'(pkt_port); sa = int'(pkt_sa); wd = int'(cfg_wdata);
      do_learn = 0;
      for (int i = 0; i < NP; i++) begin set_c[i] = 0; set_i[i] = 0; end
      if (pkt_eop && p < NP) begin
        if (sa != m_last[p] || sa != m_pref[p]) set_c[p] = 1;
        if (sa != m_pref[p] && p < IP) set_i[p] = 1;
        if (pkt_valid && sa != m_last[p] && !m_lock[p]) do_learn = 1;
      end
      for (int i = 0; i < NP; i++) begin
        bit wb;
        wb = ((wd >> i) & 1) != 0;
        if (cfg_we && cfg_sel == 3'd5 && wb) m_chg[i] = 0;
        if (cfg_we && cfg_sel == 3'd6 && wb) m_intr[i] = 0;
        if (set_c[i]) m_chg[i] = 1;
        if (set_i[i]) m_intr[i] = 1;
        if (cfg_we && cfg_sel == 3'd2) m_lock[i] = wb;
        if (cfg_we && cfg_sel == 3'd3) m_chgen[i] = wb;
        if (cfg_we && cfg_sel == 3'd4) m_intren[i] = wb && (i < IP);
      end
      if (do_learn) m_last[p] = sa;
      if (cfg_we && cfg_sel == 3'd0 && int'(cfg_port) < NP) m_pref[int'(cfg_port)] = wd;
    end
  end

  function automatic int vec(input bit v [NP]);
    int r = 0;
    for (int i = 0; i < NP; i++) if (v[i]) r |= (1 << i);
    return r;
  endfunction

  function automatic int model_rd();
    int cp = int'(cfg_port);
    case (cfg_sel)
      3'd0: return (cp < NP) ? m_pref[cp] : 0;
      3'd1: return (cp < NP) ? m_last[cp] : 0;
      3'd2: return vec(m_lock);
      3'd3: return vec(m_chgen);
      3'd4: return vec(m_intren);
      3'd5: return vec(m_chg);
      3'd6: return vec(m_intr);
      default: return 0;
    endcase
  endfunction

  function automatic bit model_irq();
    bit r = 0;
    for (int i = 0; i < NP; i++) r |= (m_chg[i] && m_chgen[i]) || (m_intr[i] && m_intren[i]);
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    check("R6 irq vs model", int'(irq), int'(model_irq()));
    check("R7 intr_status vs model", int'(intr_status), vec(m_intr));
    check("R10 cfg_rdata vs model", int'(cfg_rdata), model_rd());
  end

  task automatic idle();
    pkt_eop = 0; pkt_valid = 0; pkt_port = '0; pkt_sa = '0;
    cfg_we = 0; cfg_sel = 3'd7; cfg_port = '0; cfg_wdata = '0;
  endtask

  task automatic wr(input int sel, input int port, input int data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 3'(sel); cfg_port = PW'(port); cfg_wdata = AW'(data);
    @(posedge clk); #1;
    cfg_we = 0; cfg_sel = 3'd7;
  endtask

  task automatic pkt(input int port, input int sa, input bit valid);
    @(posedge clk); #1;
    pkt_eop = 1; pkt_port = PW'(port); pkt_sa = AW'(sa); pkt_valid = valid;
    @(posedge clk); #1;
    pkt_eop = 0; pkt_valid = 0;
  endtask

  task automatic rd(input string tag, input int sel, input int port, input int exp);
    @(posedge clk); #1;
    cfg_sel = 3'(sel); cfg_port = PW'(port);
    @(negedge clk);
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic sig(input string tag, input int act, input int exp);
    @(negedge clk);
    check(tag, act, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    sig("R9 irq after reset", int'(irq), 0);
    sig("R9 intruder status after reset", int'(intr_status), 0);
    rd("R9 learned p0 after reset", 1, 0, 0);
    rd("R9 change status after reset", 5, 0, 0);

    wr(3, 0, 'h1f);
    wr(4, 0, 'h1f);
    rd("R2 intruder enable upper bit reads 0", 4, 0, 'h0f);
    rd("R10 change enable readback", 3, 0, 'h1f);
    wr(0, 1, 'h1234);
    rd("R10 preferred p1 readback", 0, 1, 'h1234);
    rd("R10 preferred p0 untouched", 0, 0, 0);

    pkt(1, 'h1234, 1);
    rd("R1 change set on learned mismatch", 5, 0, 'h02);
    rd("R3 learned p1 updated", 1, 1, 'h1234);
    sig("R2 no intruder when preferred matches", int'(intr_status), 0);

    wr(5, 0, 'h02);
    rd("R5 write-1 clears change", 5, 0, 0);
    pkt(1, 'h1234, 1);
    rd("R1 no change when both match", 5, 0, 0);

    pkt(1, 'hbeef, 1);
    sig("R7 intruder status p1", int'(intr_status), 'h02);
    sig("R6 irq raised", int'(irq), 1);
    rd("R3 learned p1 follows", 1, 1, 'hbeef);

    wr(2, 0, 'h02);
    pkt(1, 'h5555, 1);
    rd("R4 locked port keeps learned", 1, 1, 'hbeef);
    pkt(2, 'h7777, 0);
    rd("R4 invalid packet keeps learned", 1, 2, 0);
    sig("R2 intruder set on invalid packet", int'(intr_status), 'h06);

    pkt(4, 'h1111, 1);
    rd("R2 top port raises change", 5, 0, 'h16);
    sig("R2 top port never intruder", int'(intr_status), 'h06);

    pkt(6, 'h9999, 1);
    rd("R8 out-of-range port ignored", 5, 0, 'h16);
    sig("R8 out-of-range no intruder", int'(intr_status), 'h06);

    // clear all intruder bits while port 2 sets its bit in the same cycle
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 3'd6; cfg_wdata = 'h1f;
    pkt_eop = 1; pkt_port = 3'd2; pkt_sa = 'h7777; pkt_valid = 1;
    @(posedge clk); #1;
    idle();
    sig("R5 set wins over clear", int'(intr_status), 'h04);

    wr(3, 0, 0);
    wr(4, 0, 0);
    sig("R6 masked status gives no irq", int'(irq), 0);
    wr(4, 0, 'h04);
    sig("R6 enabled intruder gives irq", int'(irq), 1);

    // random mix, checked every clock by the reference
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #1;
      idle();
      if ($urandom_range(0, 2) != 0) begin
        pkt_eop = 1; pkt_port = PW'($urandom_range(0, 7));
        pkt_sa = AW'($urandom_range(0, 3)); pkt_valid = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_sel = 3'($urandom_range(0, 7));
        cfg_port = PW'($urandom_range(0, 7)); cfg_wdata = AW'($urandom_range(0, 31));
      end else begin
        cfg_sel = 3'($urandom_range(0, 7)); cfg_port = PW'($urandom_range(0, 7));
      end
    end
    @(posedge clk); #1;
    idle();
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule